// File: doc/BRIEF.md
# Data-Move Execute Unit with Condition Codes

This unit carries out the register-level part of four simple data-move instruction forms: a sized general move, a quick signed immediate load, a sized clear, and an in-place sign extension. Each instruction is a 16-bit opcode that arrives on a one-cycle `issue` strobe. The same strobe carries a 32-bit source operand, which an upstream stage has already fetched. One clock later the unit presents its results. These are the value it wrote, the destination register index, a write indication, a base cycle count and the updated N/Z/V/C condition codes. A `done` pulse marks the results.

Results go into an internal file of sixteen 32-bit registers. Indices 0-7 are the data registers and indices 8-15 are the address registers. A combinational read port lets a neighbouring stage, or a test, look at any register. The unit does not calculate memory addresses and does not run bus cycles. For a destination that is not a register, it only updates the flags and the cycle count.

Top module: `dmove_unit`

## Requirements
- R1: Reset clears all sixteen registers, the flags, `done`, `err`, `wr`, `res`, `dst` and `cyc`.
- R2: All results appear on the clock edge that samples `issue`. `done` is high for exactly the cycles that follow an issue cycle. If nothing new is issued, `res`, `dst`, `cyc` and `flags` keep their values.
- R3: A general move has opcode[15:14]=00. Its size code in opcode[13:12] is non-linear: 1 is byte, 3 is word and 2 is long. Size code 0 is not a move and is reported as an error.
- R4: A general move takes its destination register from opcode[11:9] and its destination mode from opcode[8:6]. Mode 0 writes data register Dn. A byte or word move keeps the upper bits of Dn. Modes 2-7 write no register, and `res` then holds the sized operand, zero-extended.
- R5: A move that does not target an address register sets N to the top bit of the operand at the selected size and sets Z when that sized operand is zero. It clears V and C. The flags output is {N,Z,V,C}, with N in bit 3.
- R6: A move with destination mode 1 writes address register An (index 8+n) with all 32 bits, and a word source is sign-extended. It leaves every flag unchanged. A byte-sized move of this kind is an error.
- R7: Quick load has the layout 0111 nnn0 dddddddd. It writes Dn with the 8-bit immediate sign-extended to 32 bits. N and Z follow the value, V and C are cleared, and the cost is 4 cycles.
- R8: Clear has the layout 0100 0010 ss mmm rrr, with ss = 0 byte, 1 word, 2 long. The flags become N=0, Z=1, V=0, C=0. With mmm=0, only the sized low part of Dr is zeroed, and the cost is 4 cycles for byte or word and 6 for long. Other modes write nothing and cost 8 or 12 cycles.
- R9: Sign extension has the layout 0100 1000 1s 000 rrr. With s=0, bit 7 is copied into bits 15:8 of Dr and bits 31:16 are kept. With s=1, bit 15 is copied into bits 31:16. N and Z come from the result at the extended size, V and C are cleared, and the cost is 4 cycles.
- R10: Every general move, including a move to an address register, reports a base cost of 4 cycles.
- R11: Clear size 3, a byte move to an address register, or any opcode that is none of the four forms raises `err` with `done`. Nothing is written, and flags, `res`, `dst` and `cyc` keep their values.
- R12: `rd_data` shows register `rd_sel` combinationally, so a write is visible in the cycle that `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Execute the opcode this cycle |
| opcode | input | 16 | Instruction word |
| src_val | input | 32 | Source operand for general moves |
| rd_sel | input | 4 | Register read index (8-15 are address registers) |
| rd_data | output | 32 | Contents of the selected register |
| done | output | 1 | Result valid, one cycle after issue |
| err | output | 1 | Issued opcode was illegal |
| wr | output | 1 | The register file was written |
| dst | output | 4 | Destination register index |
| res | output | 32 | Value written, or the sized operand |
| cyc | output | 5 | Base cycle cost |
| flags | output | 4 | Condition codes {N,Z,V,C} |

## Verification
There is exactly one register stage between the issue cycle and every result. `done`, `err`, `cyc` and `flags` all change on the edge that samples `issue`. The register file is written on that same edge, and because the read port is combinational the new value is on `rd_data` right after it. The bench drives each opcode for one cycle starting at a falling edge. It then samples all outputs at the next falling edge, which is one rising edge later, and compares them with hand-derived values from an ordered vector table. Several vectors depend on register and flag state left by earlier rows, which is how preservation, flag holding and illegal-opcode no-write are checked.

// File: rtl/dmove_unit.sv
module dmove_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        issue,
  input  logic [15:0] opcode,
  input  logic [31:0] src_val,
  input  logic [3:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        done,
  output logic        err,
  output logic        wr,
  output logic [3:0]  dst,
  output logic [31:0] res,
  output logic [4:0]  cyc,
  output logic [3:0]  flags
);
  localparam int NREG = 16;

  logic [31:0] rf [NREG];

  wire is_mov  = (opcode[15:14] == 2'b00) && (opcode[13:12] != 2'b00);
  wire is_movq = (opcode[15:12] == 4'h7) && !opcode[8];
  wire is_clr  = (opcode[15:8] == 8'h42);
  wire is_ext  = (opcode[15:7] == 9'h091) && (opcode[5:3] == 3'b000);

  wire [2:0]  hi_reg = opcode[11:9];
  wire [2:0]  lo_reg = opcode[2:0];
  wire [31:0] d_hi   = rf[{1'b0, hi_reg}];
  wire [31:0] d_lo   = rf[{1'b0, lo_reg}];

  logic [31:0] n_res;
  logic [3:0]  n_dst, n_flags;
  logic [4:0]  n_cyc;
  logic        n_wr, n_err;

  always_comb begin
    n_res   = res;
    n_dst   = dst;
    n_flags = flags;
    n_cyc   = cyc;
    n_wr    = 1'b0;
    n_err   = 1'b0;
    if (is_mov) begin
      n_cyc = 5'd4;
      if (opcode[8:6] == 3'd1) begin
        n_dst = {1'b1, hi_reg};
        case (opcode[13:12])
          2'd3:    begin n_res = {{16{src_val[15]}}, src_val[15:0]}; n_wr = 1'b1; end
          2'd2:    begin n_res = src_val; n_wr = 1'b1; end
          default: begin n_err = 1'b1; n_cyc = cyc; n_res = res; n_dst = dst; end
        endcase
      end else begin
        n_dst = {1'b0, hi_reg};
        n_wr  = (opcode[8:6] == 3'd0);
        case (opcode[13:12])
          2'd1: begin
            n_res   = n_wr ? {d_hi[31:8], src_val[7:0]} : {24'd0, src_val[7:0]};
            n_flags = {src_val[7], src_val[7:0] == 8'd0, 2'b00};
          end
          2'd3: begin
            n_res   = n_wr ? {d_hi[31:16], src_val[15:0]} : {16'd0, src_val[15:0]};
            n_flags = {src_val[15], src_val[15:0] == 16'd0, 2'b00};
          end
          default: begin
            n_res   = src_val;
            n_flags = {src_val[31], src_val == 32'd0, 2'b00};
          end
        endcase
      end
    end else if (is_movq) begin
      n_res   = {{24{opcode[7]}}, opcode[7:0]};
      n_dst   = {1'b0, hi_reg};
      n_wr    = 1'b1;
      n_flags = {opcode[7], opcode[7:0] == 8'd0, 2'b00};
      n_cyc   = 5'd4;
    end else if (is_clr) begin
      if (opcode[7:6] == 2'b11) begin
        n_err = 1'b1;
      end else begin
        n_dst   = {1'b0, lo_reg};
        n_flags = 4'b0100;
        n_wr    = (opcode[5:3] == 3'd0);
        case (opcode[7:6])
          2'd0:    n_res = n_wr ? {d_lo[31:8], 8'd0}  : 32'd0;
          2'd1:    n_res = n_wr ? {d_lo[31:16], 16'd0} : 32'd0;
          default: n_res = 32'd0;
        endcase
        if (n_wr) n_cyc = (opcode[7:6] == 2'd2) ? 5'd6 : 5'd4;
        else      n_cyc = (opcode[7:6] == 2'd2) ? 5'd12 : 5'd8;
      end
    end else if (is_ext) begin
      n_dst = {1'b0, lo_reg};
      n_wr  = 1'b1;
      n_cyc = 5'd4;
      if (!opcode[6]) begin
        n_res   = {d_lo[31:16], {8{d_lo[7]}}, d_lo[7:0]};
        n_flags = {d_lo[7], d_lo[7:0] == 8'd0, 2'b00};
      end else begin
        n_res   = {{16{d_lo[15]}}, d_lo[15:0]};
        n_flags = {d_lo[15], d_lo[15:0] == 16'd0, 2'b00};
      end
    end else begin
      n_err = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      done  <= 1'b0;
      err   <= 1'b0;
      wr    <= 1'b0;
      dst   <= '0;
      res   <= '0;
      cyc   <= '0;
      flags <= '0;
    end else begin
      done <= issue;
      err  <= issue && n_err;
      wr   <= issue && n_wr && !n_err;
      if (issue && !n_err) begin
        res   <= n_res;
        dst   <= n_dst;
        cyc   <= n_cyc;
        flags <= n_flags;
        if (n_wr) rf[n_dst] <= n_res;
      end
    end
  end

  assign rd_data = rf[rd_sel];

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) issue |=> done); // R2
  AST_DONE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) !issue |=> !done && !wr); // R2
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) err |-> !wr && done); // R11
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) err |-> $stable(flags) && $stable(cyc)); // R11
  AST_MOVQ_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    issue && is_movq |=> res[31:8] == {24{res[7]}} && flags[3] == res[7]); // R7
  AST_MOVEA_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    issue && is_mov && opcode[8:6] == 3'd1 |=> $stable(flags)); // R6
  AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    issue && is_clr && opcode[7:6] != 2'b11 |=> flags == 4'b0100 && !err); // R8
  AST_VC_ZERO: assert property (@(posedge clk) disable iff (!rst_n) flags[1:0] == 2'b00); // R5
endmodule

// File: tb/tb_dmove_unit.sv
module tb_dmove_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [15:0] opcode = '0;
  logic [31:0] src_val = '0;
  logic [3:0]  rd_sel = '0;
  logic [31:0] rd_data, res;
  logic        done, err, wr;
  logic [3:0]  dst, flags;
  logic [4:0]  cyc;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  dmove_unit dut (.*);

  // op, src, sel, expected rd_data, flags, err, cyc
  localparam int NV = 20;
  localparam logic [93:0] VEC [NV] = '{
    {16'h70FF, 32'h0,        4'h0, 32'hFFFFFFFF, 4'h8, 1'b0, 5'd4},  // R7
    {16'h1000, 32'h12345600, 4'h0, 32'hFFFFFF00, 4'h4, 1'b0, 5'd4},  // R3 R4 byte
    {16'h3000, 32'hABCD8001, 4'h0, 32'hFFFF8001, 4'h8, 1'b0, 5'd4},  // R3 R4 word
    {16'h2200, 32'h0,        4'h1, 32'h00000000, 4'h4, 1'b0, 5'd4},  // R5 long zero
    {16'h2400, 32'h7FFFFFFF, 4'h2, 32'h7FFFFFFF, 4'h0, 1'b0, 5'd4},  // R5
    {16'h3640, 32'h0000F000, 4'hB, 32'hFFFFF000, 4'h0, 1'b0, 5'd4},  // R6 word
    {16'h2840, 32'h80000000, 4'hC, 32'h80000000, 4'h0, 1'b0, 5'd4},  // R6 long
    {16'h1840, 32'h11111111, 4'hC, 32'h80000000, 4'h0, 1'b1, 5'd4},  // R6 R11
    {16'h4202, 32'h0,        4'h2, 32'h7FFFFF00, 4'h4, 1'b0, 5'd4},  // R8 byte
    {16'h4282, 32'h0,        4'h2, 32'h00000000, 4'h4, 1'b0, 5'd6},  // R8 long
    {16'h42C2, 32'h0,        4'h2, 32'h00000000, 4'h4, 1'b1, 5'd6},  // R11
    {16'h7A80, 32'h0,        4'h5, 32'hFFFFFF80, 4'h8, 1'b0, 5'd4},  // R7
    {16'h2C00, 32'h123400F0, 4'h6, 32'h123400F0, 4'h0, 1'b0, 5'd4},  // R10
    {16'h4886, 32'h0,        4'h6, 32'h1234FFF0, 4'h8, 1'b0, 5'd4},  // R9 word
    {16'h48C6, 32'h0,        4'h6, 32'hFFFFFFF0, 4'h8, 1'b0, 5'd4},  // R9 long
    {16'h4881, 32'h0,        4'h1, 32'h00000000, 4'h4, 1'b0, 5'd4},  // R9 zero
    {16'h4250, 32'h0,        4'h0, 32'hFFFF8001, 4'h4, 1'b0, 5'd8},  // R8 memory
    {16'h3080, 32'h00008000, 4'h0, 32'hFFFF8001, 4'h8, 1'b0, 5'd4},  // R4 memory
    {16'h4E71, 32'h0,        4'h0, 32'hFFFF8001, 4'h8, 1'b1, 5'd4},  // R11
    {16'h0000, 32'h0,        4'h0, 32'hFFFF8001, 4'h8, 1'b1, 5'd4}   // R3 R11
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] op, input logic [31:0] sv, input logic [3:0] sel);
    @(negedge clk);
    opcode = op; src_val = sv; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0; rd_sel = sel;
    #1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 err", {31'd0, err}, 32'd0);
    chk("R1 flags", {28'd0, flags}, 32'd0);
    chk("R1 cyc", {27'd0, cyc}, 32'd0);
    for (int r = 0; r < 16; r += 5) begin
      rd_sel = r[3:0]; #1;
      chk("R1 reg", rd_data, 32'd0);
    end

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][93:78], VEC[i][77:46], VEC[i][45:42]);
      chk("R2 done", {31'd0, done}, 32'd1);
      chk("R12 rd_data", rd_data, VEC[i][41:10]);
      chk("R5 flags", {28'd0, flags}, {28'd0, VEC[i][9:6]});
      chk("R11 err", {31'd0, err}, {31'd0, VEC[i][5]});
      chk("R10 cyc", {27'd0, cyc}, {27'd0, VEC[i][4:0]});
      if (VEC[i][5]) chk("R11 wr", {31'd0, wr}, 32'd0);
    end

    @(negedge clk); #1;
    chk("R2 done low", {31'd0, done}, 32'd0);
    chk("R2 cyc hold", {27'd0, cyc}, 32'd4);

    // back-to-back issues
    @(negedge clk);
    opcode = 16'h7E05; issue = 1'b1;
    @(negedge clk);
    opcode = 16'h4287;
    #1;
    chk("R2 first done", {31'd0, done}, 32'd1);
    chk("R7 res", res, 32'h00000005);
    chk("R7 dst", {28'd0, dst}, 32'd7);
    @(negedge clk);
    issue = 1'b0; rd_sel = 4'h7; #1;
    chk("R2 second done", {31'd0, done}, 32'd1);
    chk("R8 D7 cleared", rd_data, 32'd0);
    chk("R8 wr", {31'd0, wr}, 32'd1);
    @(negedge clk); #1;
    chk("R2 done falls", {31'd0, done}, 32'd0);

    // reset again mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; rd_sel = 4'h0; #1;
    chk("R1 re-reset D0", rd_data, 32'd0);
    chk("R1 re-reset flags", {28'd0, flags}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule